// File: doc/BRIEF.md
# Configuration Request Packet Issuer

This block turns a single configuration access into a four-word request frame for a packet transmit port. A requester presents the target bus, device, function, register offset, byte enables, write data and a read/write flag on a valid/ready handshake. The block packs three header words from these fields and appends a data word. It then sends the four words one per beat, with a start marker on the first beat and an end marker on the last.

The block keeps a root bus number register, loaded through its own write strobe. This value supplies the upper byte of the requester ID in every frame. It also sets the header type: a target one bus below the root gets a type 0 request, and any other bus gets a type 1 request. The header is captured when the request is accepted, so the transmit side can stall as long as it likes. A one-cycle done pulse reports that the last beat has left.

Top module: `cfg_req_issuer`

## Requirements
- R1: After reset `tx_valid` and `done` are low, `req_ready` is high, and the root bus number is 0.
- R2: Beat 0 carries the format/type byte in bits 31:24, the value 1 in bits 9:0, and zeros in bits 23:10.
- R3: The format/type byte is 0x04 (read) or 0x44 (write) when the target bus equals the root bus number plus one, taken modulo 256. For every other bus it is 0x05 (read) or 0x45 (write).
- R4: Beat 1 is {root bus, 8'h00} in bits 31:16, the tag in bits 15:8, zeros in bits 7:4 and the byte enable in bits 3:0.
- R5: The tag is 0x1D for a read and 0x10 for a write.
- R6: Beat 2 is the bus in bits 31:24, the device in bits 23:19, the function in bits 18:16, zeros in bits 15:12, and offset bits 11:2 in bits 11:2 with bits 1:0 zero.
- R7: A frame is exactly four beats. Beat 0 has `tx_sop` set, beats 1 and 2 have neither marker, and beat 3 has `tx_eop` set. The two markers are never set together.
- R8: Beat 3 carries the write data for a write and zero for a read.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold their values into the next cycle.
- R10: `req_ready` is low from the accepting edge until the beat with `tx_eop` has been taken. A `req_valid` seen while it is low starts no frame.
- R11: `done` is high for exactly the one cycle after the edge that takes the `tx_eop` beat.
- R12: A `root_wr` pulse loads `root_wdata` into the root bus number. A load made while a frame is in flight does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_wr | input | 1 | Load strobe for the root bus number |
| root_wdata | input | 8 | New root bus number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_func | input | 3 | Target function |
| req_offset | input | 12 | Register byte offset; low two bits are ignored |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| tx_valid | output | 1 | Beat present on the transmit port |
| tx_ready | input | 1 | Transmit port takes the beat |
| tx_data | output | 32 | Beat word |
| tx_sop | output | 1 | First beat of a frame |
| tx_eop | output | 1 | Last beat of a frame |
| done | output | 1 | One-cycle pulse after a frame completes |

## Verification
The hardest case to reach is a root bus load that arrives while a frame is stalled halfway out. That frame must keep the old requester ID, and the next frame must pick up the new value. The stimulus holds `tx_ready` low, issues a request, loads 0xFF as the root bus, and then releases the port. A follow-up access to bus 0 then tests the wrap-around type 0 case. A second hard case is holding `req_valid` high, with changed fields, during a stalled frame. The scoreboard shows that no extra beats appear.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int OFS_W  = 12;
  localparam int BE_W   = 4;
  localparam int WORD_W = 32;
  localparam int N_BEATS = 4;

  localparam logic [7:0] FT_RD_T0 = 8'h04;
  localparam logic [7:0] FT_WR_T0 = 8'h44;
  localparam logic [7:0] FT_RD_T1 = 8'h05;
  localparam logic [7:0] FT_WR_T1 = 8'h45;
  localparam logic [7:0] TAG_RD   = 8'h1D;
  localparam logic [7:0] TAG_WR   = 8'h10;
  localparam logic [9:0] LEN_ONE  = 10'd1;

  typedef struct packed {
    logic              wr;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   fn;
    logic [OFS_W-1:0]  ofs;
    logic [BE_W-1:0]   be;
    logic [WORD_W-1:0] wdata;
  } cfg_req_t;

  typedef logic [N_BEATS-1:0][WORD_W-1:0] cfg_frame_t;
endpackage

// File: rtl/cfg_root_reg.sv
module cfg_root_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= din;
  end

  // R12: a load strobe takes effect on the next edge
  p_root_load_r12: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(din)));
endmodule

// File: rtl/cfg_hdr_pack.sv
module cfg_hdr_pack
  import cfg_req_pkg::*;
(
  input  cfg_req_t         req,
  input  logic [BUS_W-1:0] root,
  output cfg_frame_t       frame
);
  logic [BUS_W-1:0] child_bus;
  logic             near;
  logic [7:0]       fmt;
  logic [7:0]       tag;

  always_comb begin
    child_bus = root + BUS_W'(1);
    near      = (req.bus == child_bus);
    if (req.wr) begin
      fmt = near ? FT_WR_T0 : FT_WR_T1;
      tag = TAG_WR;
    end else begin
      fmt = near ? FT_RD_T0 : FT_RD_T1;
      tag = TAG_RD;
    end
    frame[0] = {fmt, 14'd0, LEN_ONE};
    frame[1] = {root, 8'h00, tag, 4'h0, req.be};
    frame[2] = {req.bus, req.dev, req.fn, 4'h0, req.ofs[OFS_W-1:2], 2'b00};
    frame[3] = req.wr ? req.wdata : '0;
  end
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq #(
  parameter int WORD_W  = 32,
  parameter int N_BEATS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [N_BEATS-1:0][WORD_W-1:0] frame_in,
  output logic                           busy,
  input  logic                           tx_ready,
  output logic                           tx_valid,
  output logic [WORD_W-1:0]              tx_data,
  output logic                           tx_sop,
  output logic                           tx_eop,
  output logic                           done
);
  localparam int IDX_W = (N_BEATS > 1) ? $clog2(N_BEATS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BEATS - 1);

  logic [N_BEATS-1:0][WORD_W-1:0] frame_q;
  logic [IDX_W-1:0]               idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        frame_q <= frame_in;
        idx     <= '0;
        busy    <= 1'b1;
      end else if (busy && tx_ready) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  assign tx_valid = busy;
  assign tx_data  = frame_q[idx];
  assign tx_sop   = busy && (idx == '0);
  assign tx_eop   = busy && (idx == LAST);

  // R9: a stalled beat holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));
  // R7: every frame opens with the start marker
  p_sop_first_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_sop);
  // R7: markers never coincide
  p_markers_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(tx_sop && tx_eop));
  // R11: done follows the taken end beat
  p_done_after_eop_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && tx_eop) |=> done);
  // R11: done only after a taken end beat
  p_done_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(tx_valid && tx_ready && tx_eop));
  // R10: a frame in flight is never reloaded
  p_no_reload_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);
endmodule

// File: rtl/cfg_req_issuer.sv
module cfg_req_issuer
  import cfg_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              root_wr,
  input  logic [BUS_W-1:0]  root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FN_W-1:0]   req_func,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [BE_W-1:0]   req_be,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              done
);
  cfg_req_t         req;
  cfg_frame_t       frame;
  logic [BUS_W-1:0] root_q;
  logic             busy;
  logic             accept;

  assign req = '{wr: req_write, bus: req_bus, dev: req_dev, fn: req_func,
                 ofs: req_offset, be: req_be, wdata: req_wdata};
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  cfg_root_reg #(.W(BUS_W)) u_root (
    .clk(clk), .rst(rst), .ld(root_wr), .din(root_wdata), .q(root_q)
  );

  cfg_hdr_pack u_pack (
    .req(req), .root(root_q), .frame(frame)
  );

  cfg_beat_seq #(.WORD_W(WORD_W), .N_BEATS(N_BEATS)) u_seq (
    .clk(clk), .rst(rst), .load(accept), .frame_in(frame), .busy(busy),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .done(done)
  );

  // R10: the request side is closed while beats are pending
  p_closed_busy_r10: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !req_ready);
  // R10: an accepted request opens a frame
  p_accept_opens_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (tx_valid && tx_sop));
endmodule

// File: tb/sim_cfg_req_issuer.sv
module sim_cfg_req_issuer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        root_wr = 1'b0;
  logic [7:0]  root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [11:0] req_offset = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_sop;
  logic        tx_eop;
  logic        done;

  cfg_req_issuer u0 (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [31:0] d;
    logic        sop;
    logic        eop;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails = 0;
  int   frames = 0;
  int   dones = 0;
  int   rdy_mode = 1;
  logic [7:0] root_m = 8'h00;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ready pattern driven just after each rising edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = 1'b1;
      default: tx_ready = lfsr[0] | lfsr[2];
    endcase
  end

  // monitor
  logic        stall_p = 1'b0;
  logic [31:0] data_p;
  logic        sop_p, eop_p;
  logic        eop_taken_p = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall_p)
        chk(tx_valid && tx_data == data_p && tx_sop == sop_p && tx_eop == eop_p,
            "R9 stalled beat changed", {tx_data[29:0], tx_sop, tx_eop}, {data_p[29:0], sop_p, eop_p});
      if (tx_valid)
        chk(!req_ready, "R10 req_ready high during frame", 32'(req_ready), 32'd0);
      if (done || eop_taken_p)
        chk(done == eop_taken_p, "R11 done timing", 32'(done), 32'(eop_taken_p));
      if (done) dones++;
      if (tx_valid && tx_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10 unexpected beat", tx_data, 32'hx);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(tx_data == e.d, e.tag, tx_data, e.d);
          chk(tx_sop == e.sop && tx_eop == e.eop, "R7 markers", {30'd0, tx_sop, tx_eop}, {30'd0, e.sop, e.eop});
        end
      end
      stall_p     = tx_valid && !tx_ready;
      data_p      = tx_data;
      sop_p       = tx_sop;
      eop_p       = tx_eop;
      eop_taken_p = tx_valid && tx_ready && tx_eop;
    end
  end

  task automatic push_frame(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                            input logic [2:0] fn, input logic [11:0] ofs,
                            input logic [3:0] be, input logic [31:0] wd);
    exp_t e;
    logic [7:0] ft;
    logic [7:0] child;
    child = root_m + 8'd1;
    if (bus == child) ft = wr ? 8'h44 : 8'h04;
    else              ft = wr ? 8'h45 : 8'h05;
    e.d = {ft, 14'd0, 10'd1};                                   e.sop = 1; e.eop = 0; e.tag = "R2 R3 header word 0"; sb.push_back(e);
    e.d = {root_m, 8'h00, (wr ? 8'h10 : 8'h1D), 4'h0, be};       e.sop = 0; e.eop = 0; e.tag = "R4 R5 header word 1"; sb.push_back(e);
    e.d = {bus, dev, fn, 4'h0, ofs[11:2], 2'b00};                e.sop = 0; e.eop = 0; e.tag = "R6 header word 2"; sb.push_back(e);
    e.d = wr ? wd : 32'd0;                                       e.sop = 0; e.eop = 1; e.tag = "R8 data word"; sb.push_back(e);
    frames++;
  endtask

  task automatic issue(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                       input logic [2:0] fn, input logic [11:0] ofs,
                       input logic [3:0] be, input logic [31:0] wd, input int hold);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bus = bus; req_dev = dev; req_func = fn;
    req_offset = ofs; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    push_frame(wr, bus, dev, fn, ofs, be, wd);
    @(posedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      req_write = ~wr; req_bus = bus + 8'd3; req_wdata = ~wd;
      chk(!req_ready, "R10 request accepted while busy", 32'(req_ready), 32'd0);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic load_root(input logic [7:0] v);
    @(negedge clk);
    root_wr = 1; root_wdata = v;
    @(negedge clk);
    root_wr = 0;
    root_m = v;
  endtask

  task automatic wait_idle;
    do @(negedge clk); while (sb.size() != 0 || !req_ready);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_valid && !done && req_ready, "R1 reset outputs",
        {29'd0, tx_valid, done, req_ready}, 32'd1);
    rst = 0;
    // R1: root starts at 0, so bus 1 is the near bus
    issue(0, 8'd1, 5'd0, 3'd0, 12'h010, 4'hF, 32'h0, 0);
    issue(1, 8'd1, 5'd2, 3'd1, 12'h003, 4'h2, 32'hCAFE_F00D, 0);
    issue(0, 8'd0, 5'd0, 3'd0, 12'h000, 4'hF, 32'h0, 0);
    wait_idle();
    // R12 load, then near and far buses (R3)
    load_root(8'd5);
    issue(0, 8'd6, 5'h1F, 3'd7, 12'hFFC, 4'hC, 32'h0, 0);
    issue(1, 8'd9, 5'd3, 3'd2, 12'h0A7, 4'h1, 32'h1234_5678, 0);
    issue(0, 8'd5, 5'd1, 3'd0, 12'h100, 4'h3, 32'h0, 0);
    wait_idle();
    // R9 random backpressure
    rdy_mode = 2;
    for (int k = 0; k < 8; k++)
      issue(k[0], 8'(k + 4), 5'(k * 3), 3'(k), 12'(k * 37), 4'(k + 1), 32'hA5A5_0000 + k, 0);
    wait_idle();
    // R12: root load while a frame is stalled
    rdy_mode = 0;
    issue(1, 8'd6, 5'd4, 3'd3, 12'h044, 4'hF, 32'hDEAD_BEEF, 0);
    load_root(8'hFF);
    repeat (3) @(negedge clk);
    rdy_mode = 1;
    wait_idle();
    // R3 wrap: root 0xFF makes bus 0 the near bus
    issue(0, 8'd0, 5'd0, 3'd0, 12'h008, 4'hF, 32'h0, 0);
    issue(1, 8'hFF, 5'd0, 3'd0, 12'h00C, 4'h8, 32'h0BAD_F00D, 0);
    wait_idle();
    // R10: request held during a stalled frame
    rdy_mode = 0;
    issue(0, 8'd7, 5'd1, 3'd1, 12'h020, 4'h6, 32'h0, 5);
    rdy_mode = 1;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R7 beats missing", 32'(sb.size()), 32'd0);
    chk(dones == frames, "R11 done count", 32'(dones), 32'(frames));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule